// File: doc/BRIEF.md
# Software Flow Controller for a Byte Serial Link

This block carries in-band flow control for a byte-wide serial port. It sits between the receive deserializer, the receive FIFO, the transmit FIFO and the transmit serializer. Two reserved byte values are pulled out of the received stream. One of them pauses the local data transmitter and the other resumes it. The block also watches the receive FIFO fill level. It asks the remote end to stop sending when the level climbs to a high mark. It asks the remote end to resume when the consumer has drained the FIFO below a low mark.

Flow characters that cannot leave at once, because the serializer is busy, are held as pending. A pending flow character always goes out ahead of queued data. A stop request from the remote end blocks only data, so local flow characters are never held back by it. Software can force either direction into the stopped or running state. A sticky overrun flag records bytes that arrived while the FIFO was full.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: After reset, `fifo_wr`, `ser_valid`, `txq_ready`, `rx_disabled`, `tx_disabled` and `ovr_err` are all low.
- R2: With `fc_en` high, a received 0x13 (stop) raises `tx_disabled` on the next cycle, and a received 0x11 (resume) lowers it.
- R3: With `fc_en` high, received 0x11 and 0x13 never assert `fifo_wr` and never set `ovr_err`, even when `fifo_level` equals DEPTH. With `fc_en` low, they pass to the FIFO as ordinary data.
- R4: When a data write makes the count (`fifo_level`+1) reach HWM while `rx_disabled` is low, 0x13 is presented on `ser_data` with `ser_valid` in the same cycle if `ser_ready` is high. Otherwise it waits for the first cycle with `ser_ready` high. `rx_disabled` rises on the cycle after it goes out.
- R5: In a cycle with `ser_ready` high, a pending flow character is sent and `txq_ready` stays low, even if `txq_valid` is high.
- R6: While `tx_disabled` is high, `txq_ready` stays low, but flow characters are still sent.
- R7: A non-flow byte that arrives while `fifo_level` is at least DEPTH is not written, and it sets `ovr_err` on the next cycle. `ovr_err` then stays high until `err_clr`.
- R8: A `drain` pulse with `fifo_level` below LWM while `rx_disabled` is high sends 0x11, at once or as pending. `rx_disabled` falls on the next cycle.
- R9: Only one of the two flow characters can be pending at a time. A new stop request made while a resume is pending replaces it, so only 0x13 goes out.
- R10: A rising edge of `fc_en` raises `rx_disabled`, so the first qualifying drain sends 0x11. While `fc_en` is low, both status outputs are low.
- R11: `force_rx_off` and `force_rx_on` set and clear `rx_disabled` without sending anything. `force_tx_off` and `force_tx_on` set and clear `tx_disabled`.
- R12: `err_clr` clears `ovr_err` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_en | input | 1 | Flow control enable (level) |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | DATA_W | Received byte |
| fifo_level | input | LVL_W | Receive FIFO fill count |
| drain | input | 1 | Consumer has removed bytes from the receive FIFO |
| fifo_wr | output | 1 | Write strobe to the receive FIFO |
| fifo_wdata | output | DATA_W | Byte written to the receive FIFO |
| txq_valid | input | 1 | Transmit FIFO has a data byte |
| txq_data | input | DATA_W | Transmit FIFO head byte |
| txq_ready | output | 1 | Data byte taken from the transmit FIFO |
| ser_ready | input | 1 | Serializer can accept a byte this cycle |
| ser_valid | output | 1 | Byte handed to the serializer |
| ser_data | output | DATA_W | Byte to the serializer |
| force_rx_off | input | 1 | Software: mark receive side stopped |
| force_rx_on | input | 1 | Software: mark receive side running |
| force_tx_off | input | 1 | Software: mark transmit side stopped |
| force_tx_on | input | 1 | Software: mark transmit side running |
| err_clr | input | 1 | Clear the overrun flag |
| rx_disabled | output | 1 | A stop request is in force toward the remote end |
| tx_disabled | output | 1 | The remote end has stopped local data |
| ovr_err | output | 1 | Sticky receive overrun |

## Verification
A corrupted sent-stop flag shows up on `rx_disabled` one cycle later. It also shows up as a missing or duplicated 0x11 or 0x13 on `ser_data` at the next high-mark crossing or drain event. A lost or doubled pending flag appears on the first cycle with `ser_ready` high, either as a data byte taking the slot or as a flow character sent twice. A wrong remote-stop state shows on `txq_ready` in the same cycle that `txq_valid` and `ser_ready` are both high. The sweeps cover every received byte value and every fill level, so a filter or threshold error is exposed at the first affected value.

// File: rtl/fc_pkg.sv
package fc_pkg;
   localparam logic [7:0] RESUME_CODE = 8'h11;
   localparam logic [7:0] STOP_CODE   = 8'h13;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_STOP = 2'd1,
      SEL_RES  = 2'd2,
      SEL_DATA = 2'd3
   } tx_sel_e;
endpackage

// File: rtl/fc_rx_filter.sv
module fc_rx_filter #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int HWM    = 12,
   parameter int LVL_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic [LVL_W-1:0]  level,
   output logic              fifo_wr,
   output logic [DATA_W-1:0] fifo_wdata,
   output logic              got_stop,
   output logic              got_res,
   output logic              overrun_evt,
   output logic              hwm_hit
);
   import fc_pkg::*;

   localparam logic [LVL_W-1:0] FULL_C = LVL_W'(DEPTH);
   localparam logic [LVL_W:0]   HWM_C  = (LVL_W+1)'(HWM);

   logic is_stop, is_res, is_flow, full;

   always_comb begin
      is_stop     = en && (rx_data == DATA_W'(STOP_CODE));
      is_res      = en && (rx_data == DATA_W'(RESUME_CODE));
      is_flow     = is_stop || is_res;
      full        = (level >= FULL_C);
      got_stop    = rx_valid && is_stop;
      got_res     = rx_valid && is_res;
      fifo_wr     = rx_valid && !is_flow && !full;
      overrun_evt = rx_valid && !is_flow && full;
      fifo_wdata  = rx_data;
      hwm_hit     = fifo_wr && (({1'b0, level} + 1'b1) >= HWM_C);
   end

   AST_FLOW_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr && en) |-> (fifo_wdata != DATA_W'(STOP_CODE) && fifo_wdata != DATA_W'(RESUME_CODE))); // R3
   AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr |-> (level < FULL_C)); // R7
endmodule

// File: rtl/fc_flag_ctrl.sv
module fc_flag_ctrl #(
   parameter int DEPTH     = 16,
   parameter int LWM       = 4,
   parameter bit SAME_SLOT = 1'b1,
   parameter int LVL_W     = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             got_stop,
   input  logic             got_res,
   input  logic             hwm_hit,
   input  logic             overrun_evt,
   input  logic             drain,
   input  logic [LVL_W-1:0] level,
   input  logic             sent_stop,
   input  logic             sent_res,
   input  logic             force_rx_off,
   input  logic             force_rx_on,
   input  logic             force_tx_off,
   input  logic             force_tx_on,
   input  logic             err_clr,
   output logic             stop_req,
   output logic             res_req,
   output logic             remote_halt,
   output logic             stop_out,
   output logic             ovr
);
   localparam logic [LVL_W-1:0] LWM_C = LVL_W'(LWM);

   logic en_q, stop_pend, res_pend;
   logic stop_trig, res_trig;

   always_comb begin
      stop_trig = en && hwm_hit && !stop_out && !stop_pend;
      res_trig  = en && drain && stop_out && (level < LWM_C);
   end

   generate
      if (SAME_SLOT) begin : g_same
         always_comb begin
            stop_req = (stop_pend && !res_trig) || stop_trig;
            res_req  = (res_pend && !stop_trig) || res_trig;
         end
      end else begin : g_next
         always_comb begin
            stop_req = stop_pend;
            res_req  = res_pend && !stop_trig;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q        <= 1'b0;
         stop_pend   <= 1'b0;
         res_pend    <= 1'b0;
         stop_out    <= 1'b0;
         remote_halt <= 1'b0;
         ovr         <= 1'b0;
      end else begin
         en_q <= en;
         if (overrun_evt)  ovr <= 1'b1;
         else if (err_clr) ovr <= 1'b0;
         if (!en) begin
            stop_pend   <= 1'b0;
            res_pend    <= 1'b0;
            stop_out    <= 1'b0;
            remote_halt <= 1'b0;
         end else if (!en_q) begin
            stop_pend   <= 1'b0;
            res_pend    <= 1'b0;
            stop_out    <= 1'b1;
            remote_halt <= 1'b0;
         end else begin
            stop_pend <= ((stop_pend && !res_trig) || stop_trig) && !sent_stop;
            res_pend  <= ((res_pend && !stop_trig) || res_trig) && !sent_res;
            if (sent_stop)                stop_out <= 1'b1;
            else if (res_trig || sent_res) stop_out <= 1'b0;
            if (force_rx_off || force_rx_on) begin
               stop_out  <= force_rx_off;
               stop_pend <= 1'b0;
               res_pend  <= 1'b0;
            end
            if (got_stop || force_tx_off)    remote_halt <= 1'b1;
            else if (got_res || force_tx_on) remote_halt <= 1'b0;
         end
      end
   end

   AST_PEND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(stop_pend && res_pend)); // R9
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !err_clr) |=> ovr); // R7
   AST_STOP_MARKS_SENT: assert property (@(posedge clk) disable iff (!rst_n)
      (en && en_q && sent_stop && !force_rx_on) |=> stop_out); // R4
   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!stop_out && !remote_halt)); // R10
endmodule

// File: rtl/fc_tx_arb.sv
module fc_tx_arb #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stop_req,
   input  logic              res_req,
   input  logic              remote_halt,
   input  logic              ser_ready,
   input  logic              txq_valid,
   input  logic [DATA_W-1:0] txq_data,
   output logic              ser_valid,
   output logic [DATA_W-1:0] ser_data,
   output logic              txq_ready,
   output logic              sent_stop,
   output logic              sent_res
);
   import fc_pkg::*;

   tx_sel_e sel;

   always_comb begin
      if (!ser_ready)                     sel = SEL_NONE;
      else if (stop_req)                  sel = SEL_STOP;
      else if (res_req)                   sel = SEL_RES;
      else if (txq_valid && !remote_halt) sel = SEL_DATA;
      else                                sel = SEL_NONE;
      ser_valid = (sel != SEL_NONE);
      txq_ready = (sel == SEL_DATA);
      sent_stop = (sel == SEL_STOP);
      sent_res  = (sel == SEL_RES);
      case (sel)
         SEL_STOP: ser_data = DATA_W'(STOP_CODE);
         SEL_RES:  ser_data = DATA_W'(RESUME_CODE);
         SEL_DATA: ser_data = txq_data;
         default:  ser_data = '0;
      endcase
   end

   AST_FLOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req || res_req) |-> !txq_ready); // R5
   AST_HALT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      remote_halt |-> !txq_ready); // R6
   AST_ONE_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !(sent_stop && sent_res)); // R9
endmodule

// File: rtl/xonxoff_flow_ctrl.sv
module xonxoff_flow_ctrl #(
   parameter int DATA_W    = 8,
   parameter int DEPTH     = 16,
   parameter int HWM       = 12,
   parameter int LWM       = 4,
   parameter bit SAME_SLOT = 1'b1,
   parameter int LVL_W     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fc_en,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic [LVL_W-1:0]  fifo_level,
   input  logic              drain,
   output logic              fifo_wr,
   output logic [DATA_W-1:0] fifo_wdata,
   input  logic              txq_valid,
   input  logic [DATA_W-1:0] txq_data,
   output logic              txq_ready,
   input  logic              ser_ready,
   output logic              ser_valid,
   output logic [DATA_W-1:0] ser_data,
   input  logic              force_rx_off,
   input  logic              force_rx_on,
   input  logic              force_tx_off,
   input  logic              force_tx_on,
   input  logic              err_clr,
   output logic              rx_disabled,
   output logic              tx_disabled,
   output logic              ovr_err
);
   generate
      if (DATA_W < 8)              begin : g_bad_w   $error("DATA_W below 8");      end
      if (HWM < 1 || HWM > DEPTH)  begin : g_bad_hwm $error("HWM out of range");    end
      if (LWM < 1 || LWM >= HWM)   begin : g_bad_lwm $error("LWM must be below HWM"); end
      if (LVL_W < $clog2(DEPTH+1)) begin : g_bad_lvl $error("LVL_W too narrow");    end
   endgenerate

   logic got_stop, got_res, overrun_evt, hwm_hit;
   logic stop_req, res_req, remote_halt, stop_out, ovr;
   logic sent_stop, sent_res;

   fc_rx_filter #(.DATA_W(DATA_W), .DEPTH(DEPTH), .HWM(HWM), .LVL_W(LVL_W)) u_filt (
      .clk(clk), .rst_n(rst_n), .en(fc_en), .rx_valid(rx_valid), .rx_data(rx_data),
      .level(fifo_level), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
      .got_stop(got_stop), .got_res(got_res), .overrun_evt(overrun_evt), .hwm_hit(hwm_hit)
   );

   fc_flag_ctrl #(.DEPTH(DEPTH), .LWM(LWM), .SAME_SLOT(SAME_SLOT), .LVL_W(LVL_W)) u_flags (
      .clk(clk), .rst_n(rst_n), .en(fc_en), .got_stop(got_stop), .got_res(got_res),
      .hwm_hit(hwm_hit), .overrun_evt(overrun_evt), .drain(drain), .level(fifo_level),
      .sent_stop(sent_stop), .sent_res(sent_res),
      .force_rx_off(force_rx_off), .force_rx_on(force_rx_on),
      .force_tx_off(force_tx_off), .force_tx_on(force_tx_on), .err_clr(err_clr),
      .stop_req(stop_req), .res_req(res_req), .remote_halt(remote_halt),
      .stop_out(stop_out), .ovr(ovr)
   );

   fc_tx_arb #(.DATA_W(DATA_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .res_req(res_req),
      .remote_halt(remote_halt), .ser_ready(ser_ready), .txq_valid(txq_valid),
      .txq_data(txq_data), .ser_valid(ser_valid), .ser_data(ser_data),
      .txq_ready(txq_ready), .sent_stop(sent_stop), .sent_res(sent_res)
   );

   assign rx_disabled = stop_out;
   assign tx_disabled = remote_halt;
   assign ovr_err     = ovr;

   AST_OVR_ONLY_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_err && !overrun_evt) |=> !ovr_err); // R7
   AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clr && !overrun_evt) |=> !ovr_err); // R12
endmodule

// File: tb/sim_xonxoff_flow_ctrl.sv
module sim_xonxoff_flow_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8, DEPTH = 16, HWM = 12, LWM = 4;
   localparam int LW = $clog2(DEPTH + 1);

   logic clk = 1'b0, rst_n = 1'b0, fc_en = 1'b0;
   logic rx_valid = 1'b0, drain = 1'b0, txq_valid = 1'b0, ser_ready = 1'b0;
   logic force_rx_off = 1'b0, force_rx_on = 1'b0, force_tx_off = 1'b0, force_tx_on = 1'b0;
   logic err_clr = 1'b0;
   logic [DW-1:0] rx_data = '0, txq_data = '0;
   logic [LW-1:0] fifo_level = '0;
   logic fifo_wr, txq_ready, ser_valid, rx_disabled, tx_disabled, ovr_err;
   logic [DW-1:0] fifo_wdata, ser_data;
   int checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xonxoff_flow_ctrl #(.DATA_W(DW), .DEPTH(DEPTH), .HWM(HWM), .LWM(LWM)) u0 (
      .clk(clk), .rst_n(rst_n), .fc_en(fc_en), .rx_valid(rx_valid), .rx_data(rx_data),
      .fifo_level(fifo_level), .drain(drain), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
      .txq_valid(txq_valid), .txq_data(txq_data), .txq_ready(txq_ready),
      .ser_ready(ser_ready), .ser_valid(ser_valid), .ser_data(ser_data),
      .force_rx_off(force_rx_off), .force_rx_on(force_rx_on),
      .force_tx_off(force_tx_off), .force_tx_on(force_tx_on), .err_clr(err_clr),
      .rx_disabled(rx_disabled), .tx_disabled(tx_disabled), .ovr_err(ovr_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk); #1;
   endtask

   task automatic fresh();   // flow on, receive side running
      fc_en = 1'b0; cyc(); fc_en = 1'b1; cyc();
      force_rx_on = 1'b1; cyc(); force_rx_on = 1'b0;
      err_clr = 1'b1; cyc(); err_clr = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      cyc(); cyc(); rst_n = 1'b1; cyc();
      // R1 reset state
      chk("R1 fifo_wr", fifo_wr, 0); chk("R1 ser_valid", ser_valid, 0);
      chk("R1 txq_ready", txq_ready, 0); chk("R1 rx_disabled", rx_disabled, 0);
      chk("R1 tx_disabled", tx_disabled, 0); chk("R1 ovr_err", ovr_err, 0);

      // R10 enable edge marks receive side stopped; R8 first drain sends resume
      fc_en = 1'b1; cyc();
      chk("R10 rx_disabled on enable", rx_disabled, 1);
      fifo_level = 2; drain = 1'b1; ser_ready = 1'b1; #1;
      chk("R8 resume sent", ser_valid, 1); chk("R8 resume code", ser_data, 8'h11);
      cyc(); drain = 1'b0; ser_ready = 1'b0;
      chk("R8 rx_disabled cleared", rx_disabled, 0);

      // R3 sweep all bytes, enabled, level 5
      fifo_level = 5;
      for (int b = 0; b < 256; b++) begin
         rx_valid = 1'b1; rx_data = DW'(b); #1;
         chk("R3 enabled filter", fifo_wr, (b == 8'h11 || b == 8'h13) ? 0 : 1);
         if (fifo_wr) chk("R3 wdata", fifo_wdata, b);
         cyc();
      end
      rx_valid = 1'b0; cyc();
      // R3 flow chars at full: no write, no overrun
      fifo_level = DEPTH;
      rx_valid = 1'b1; rx_data = 8'h13; #1; chk("R3 stop at full", fifo_wr, 0); cyc();
      rx_data = 8'h11; #1; chk("R3 resume at full", fifo_wr, 0); cyc();
      rx_valid = 1'b0; cyc();
      chk("R3 no overrun from flow", ovr_err, 0);
      // R7 every byte at full, enabled
      for (int b = 0; b < 256; b++) begin
         rx_valid = 1'b1; rx_data = DW'(b); #1;
         chk("R7 no write when full", fifo_wr, 0);
         cyc();
      end
      rx_valid = 1'b0; cyc(); cyc();
      chk("R7 overrun sticky", ovr_err, 1);
      err_clr = 1'b1; cyc(); err_clr = 1'b0;
      chk("R12 err_clr", ovr_err, 0);

      // R3 disabled: all bytes pass
      fc_en = 1'b0; fifo_level = 3; cyc();
      chk("R10 disabled status", {30'd0, rx_disabled, tx_disabled}, 0);
      for (int b = 0; b < 256; b++) begin
         rx_valid = 1'b1; rx_data = DW'(b); #1;
         chk("R3 disabled passthrough", fifo_wr, 1);
         cyc();
      end
      rx_valid = 1'b0; cyc();
      chk("R3 disabled no halt", tx_disabled, 0);

      // R4 R7 level sweep with ready serializer
      for (int l = 0; l <= DEPTH; l++) begin
         fresh();
         fifo_level = LW'(l); rx_valid = 1'b1; rx_data = 8'h41; ser_ready = 1'b1; #1;
         chk("R7 write below full", fifo_wr, (l < DEPTH) ? 1 : 0);
         chk("R4 stop same cycle", ser_valid, (l < DEPTH && l + 1 >= HWM) ? 1 : 0);
         if (ser_valid) chk("R4 stop code", ser_data, 8'h13);
         cyc(); rx_valid = 1'b0; ser_ready = 1'b0;
         chk("R7 overrun flag", ovr_err, (l == DEPTH) ? 1 : 0);
         chk("R4 rx_disabled", rx_disabled, (l < DEPTH && l + 1 >= HWM) ? 1 : 0);
      end

      // R4 pending and R5 priority over data
      fresh();
      fifo_level = HWM - 1; rx_valid = 1'b1; rx_data = 8'h42; #1;
      chk("R4 held while busy", ser_valid, 0);
      cyc(); rx_valid = 1'b0;
      chk("R4 not yet marked", rx_disabled, 0);
      txq_valid = 1'b1; txq_data = 8'h55; ser_ready = 1'b1; #1;
      chk("R5 flow first", ser_data, 8'h13); chk("R5 data held", txq_ready, 0);
      cyc();
      chk("R4 marked after send", rx_disabled, 1);
      chk("R5 data next", ser_data, 8'h55); chk("R5 data taken", txq_ready, 1);
      ser_ready = 1'b0; txq_valid = 1'b0; cyc();

      // R2 R6 remote stop blocks data only
      rx_valid = 1'b1; rx_data = 8'h13; cyc(); rx_valid = 1'b0;
      chk("R2 stop received", tx_disabled, 1);
      txq_valid = 1'b1; ser_ready = 1'b1; #1;
      chk("R6 no data while halted", txq_ready, 0);
      fifo_level = 1; drain = 1'b1; #1;
      chk("R6 resume still sent", ser_data, 8'h11);
      cyc(); drain = 1'b0; ser_ready = 1'b0;
      rx_valid = 1'b1; rx_data = 8'h11; cyc(); rx_valid = 1'b0;
      chk("R2 resume received", tx_disabled, 0);
      ser_ready = 1'b1; #1;
      chk("R2 data flows again", txq_ready, 1);
      ser_ready = 1'b0; txq_valid = 1'b0; cyc();

      // R8 drain above low mark ignored
      force_rx_off = 1'b1; cyc(); force_rx_off = 1'b0;
      chk("R11 force rx off", rx_disabled, 1);
      fifo_level = LW'(LWM); drain = 1'b1; ser_ready = 1'b1; #1;
      chk("R8 no resume at low mark", ser_valid, 0);
      cyc(); drain = 1'b0; ser_ready = 1'b0;
      chk("R8 still disabled", rx_disabled, 1);

      // R9 stop replaces pending resume
      fifo_level = 2; drain = 1'b1; cyc(); drain = 1'b0;
      chk("R8 pending resume clears flag", rx_disabled, 0);
      fifo_level = HWM - 1; rx_valid = 1'b1; rx_data = 8'h20; cyc(); rx_valid = 1'b0;
      ser_ready = 1'b1; #1;
      chk("R9 stop goes out", ser_data, 8'h13);
      cyc();
      chk("R9 resume dropped", ser_valid, 0);
      ser_ready = 1'b0; cyc();

      // R11 overrides
      force_rx_on = 1'b1; cyc(); force_rx_on = 1'b0;
      chk("R11 force rx on", rx_disabled, 0);
      force_tx_off = 1'b1; cyc(); force_tx_off = 1'b0;
      chk("R11 force tx off", tx_disabled, 1);
      force_tx_on = 1'b1; cyc(); force_tx_on = 1'b0;
      chk("R11 force tx on", tx_disabled, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule